// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block turns a qualified PWM level into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. Besides the PWM level it reads a flag that marks the PWM line as floating, a mode level that chooses forced-continuous or diode-emulation operation, a flag that marks the mode line as floating, and an undervoltage-lockout flag. It also reads one gate-below-threshold comparator flag for each gate and a zero-cross flag from the switch node.

Dead time adapts to the gates themselves. On every PWM transition the gate that is conducting is released first. The opposite gate is enabled only after the comparator flag reports the released gate below threshold. In diode-emulation mode, a falling PWM edge opens a low-side pulse. A zero cross ends that pulse, but only after a minimum on-time. If a comparator flag fails to arrive within a bounded window, the sequencer parks with both gates off and stays there until the next PWM edge. All delays are counted in clock cycles.

Top module: `buck_gate_seq`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, both gate enables are 0.
- R2: hs_en_o and ls_en_o are never 1 in the same cycle.
- R3: With mode_i = 1 (continuous), PWM high gives hs_en_o = 1 and ls_en_o = 0, and PWM low gives ls_en_o = 1 and hs_en_o = 0. Each change passes through at least one cycle with both enables at 0. The new gate turns on two clock edges after the PWM change when feedback is already present.
- R4: The high side turns on only at an edge where ls_below_i was 1 in the preceding cycle. The low side turns on only at an edge where hs_below_i was 1 in the preceding cycle. While that flag stays 0, both enables stay 0.
- R5: With mode_i = 0 (diode emulation), a falling PWM edge opens a low-side pulse. zero_cross_i = 1 ends that pulse, and both enables are then 0.
- R6: In diode emulation, zero_cross_i is ignored until the low side has been on for MIN_ON_CYC cycles. A PWM rise always ends the pulse, even in the same cycle as a zero cross.
- R7: pwm_float_i = 1 forces both enables to 0 in that cycle and keeps them at 0 while it stays asserted.
- R8: mode_float_i = 1 forces both enables to 0 regardless of pwm_i.
- R9: uvlo_i = 1 forces both enables to 0. When it clears, normal sequencing resumes from the present PWM level.
- R10: If the awaited below-threshold flag is still 0 after FB_TIMEOUT_CYC cycles of waiting, both enables go to 0 and stay at 0 until pwm_i changes. The flag is still honoured if it arrives in the last cycle of the window.
- R11: In diode emulation with PWM low and no pulse open, the low side stays off. Switching mode_i to 1 in that state turns the low side on after the high side is confirmed low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Qualified PWM level |
| pwm_float_i | input | 1 | PWM line detected as floating |
| mode_i | input | 1 | 1 = continuous, 0 = diode emulation |
| mode_float_i | input | 1 | Mode line detected as floating |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| hs_below_i | input | 1 | High-side gate below turn-on threshold |
| ls_below_i | input | 1 | Low-side gate below turn-on threshold |
| zero_cross_i | input | 1 | Switch-node current zero cross detected |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the expiry of the minimum low-side on-time with a zero cross, together with a PWM rise. The second pair is the last cycle of the feedback window together with the arrival of the feedback flag. The bench drives the PWM rise and the zero cross on exactly the edge at which the minimum on-time completes. Both enables must be 0 at that edge, and the high side must follow one edge later. The bench also raises the below-threshold flag in the final waiting cycle, and the low side must then turn on instead of parking.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF         = 3'd0,
    ST_HS_ON       = 3'd1,
    ST_WAIT_HS_LOW = 3'd2,
    ST_LS_ON       = 3'd3,
    ST_WAIT_LS_LOW = 3'd4,
    ST_LS_IDLE     = 3'd5
  } seq_state_e;

endpackage

// File: rtl/buck_input_cond.sv
module buck_input_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic pwm_float_i,
  input  logic mode_i,
  input  logic mode_float_i,
  input  logic uvlo_i,
  output logic kill_o,
  output logic ccm_o,
  output logic pwm_edge_o
);

  logic pwm_q;

  // Remember last PWM level for edge detection.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
    end
  end

  always_comb begin
    kill_o     = uvlo_i | pwm_float_i | mode_float_i;
    ccm_o      = mode_i;
    pwm_edge_o = pwm_i ^ pwm_q;
  end

endmodule

// File: rtl/buck_dwell_timer.sv
module buck_dwell_timer #(
  parameter int unsigned MIN_ON_CYC     = 120,
  parameter int unsigned FB_TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic min_done_o,
  output logic fb_expired_o
);

  localparam int unsigned CNT_MAX = (MIN_ON_CYC > FB_TIMEOUT_CYC) ? MIN_ON_CYC : FB_TIMEOUT_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] MIN_LAST   = CNT_W'(MIN_ON_CYC - 1);
  localparam logic [CNT_W-1:0] FB_LAST    = CNT_W'(FB_TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Counts cycles spent in the current state; saturates at the top.
  always_comb begin
    cnt_en = restart_i || (cnt_q != CNT_TOP);
    cnt_d  = restart_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    min_done_o   = (cnt_q >= MIN_LAST);
    fb_expired_o = (cnt_q >= FB_LAST);
  end

endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
  import buck_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kill_i,
  input  logic       ccm_i,
  input  logic       pwm_i,
  input  logic       pwm_edge_i,
  input  logic       hs_below_i,
  input  logic       ls_below_i,
  input  logic       zero_cross_i,
  input  logic       min_done_i,
  input  logic       fb_expired_i,
  output seq_state_e state_o,
  output logic       restart_o
);

  seq_state_e state_q, state_d;
  logic       stall_q, stall_d;
  logic       may_leave_off;

  always_comb begin
    state_d       = state_q;
    stall_d       = stall_q;
    may_leave_off = !stall_q || pwm_edge_i;
    if (pwm_edge_i) begin
      stall_d = 1'b0;
    end
    if (kill_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (may_leave_off) begin
            if (pwm_i)      state_d = ST_WAIT_LS_LOW;
            else if (ccm_i) state_d = ST_WAIT_HS_LOW;
            else            state_d = ST_LS_IDLE;
          end
        end
        ST_WAIT_LS_LOW: begin
          if (!pwm_i) begin
            state_d = ccm_i ? ST_WAIT_HS_LOW : ST_LS_IDLE;
          end else if (ls_below_i) begin
            state_d = ST_HS_ON;
          end else if (fb_expired_i) begin
            state_d = ST_OFF;
            stall_d = 1'b1;
          end
        end
        ST_HS_ON: begin
          if (!pwm_i) state_d = ST_WAIT_HS_LOW;
        end
        ST_WAIT_HS_LOW: begin
          if (pwm_i) begin
            state_d = ST_WAIT_LS_LOW;
          end else if (hs_below_i) begin
            state_d = ST_LS_ON;
          end else if (fb_expired_i) begin
            state_d = ST_OFF;
            stall_d = 1'b1;
          end
        end
        ST_LS_ON: begin
          if (pwm_i) begin
            state_d = ST_WAIT_LS_LOW;
          end else if (!ccm_i && min_done_i && zero_cross_i) begin
            state_d = ST_LS_IDLE;
          end
        end
        ST_LS_IDLE: begin
          if (pwm_i)      state_d = ST_WAIT_LS_LOW;
          else if (ccm_i) state_d = ST_WAIT_HS_LOW;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      stall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stall_q <= stall_d;
    end
  end

  always_comb begin
    state_o   = state_q;
    restart_o = (state_d != state_q);
  end

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int unsigned MIN_ON_CYC     = 120,
  parameter int unsigned FB_TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic pwm_float_i,
  input  logic mode_i,
  input  logic mode_float_i,
  input  logic uvlo_i,
  input  logic hs_below_i,
  input  logic ls_below_i,
  input  logic zero_cross_i,
  output logic hs_en_o,
  output logic ls_en_o
);

  logic       kill;
  logic       ccm;
  logic       pwm_edge;
  logic       min_done;
  logic       fb_expired;
  logic       restart;
  seq_state_e state;

  buck_input_cond u_cond (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwm_i        (pwm_i),
    .pwm_float_i  (pwm_float_i),
    .mode_i       (mode_i),
    .mode_float_i (mode_float_i),
    .uvlo_i       (uvlo_i),
    .kill_o       (kill),
    .ccm_o        (ccm),
    .pwm_edge_o   (pwm_edge)
  );

  buck_dwell_timer #(
    .MIN_ON_CYC     (MIN_ON_CYC),
    .FB_TIMEOUT_CYC (FB_TIMEOUT_CYC)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .min_done_o   (min_done),
    .fb_expired_o (fb_expired)
  );

  buck_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kill_i       (kill),
    .ccm_i        (ccm),
    .pwm_i        (pwm_i),
    .pwm_edge_i   (pwm_edge),
    .hs_below_i   (hs_below_i),
    .ls_below_i   (ls_below_i),
    .zero_cross_i (zero_cross_i),
    .min_done_i   (min_done),
    .fb_expired_i (fb_expired),
    .state_o      (state),
    .restart_o    (restart)
  );

  // Any inhibit source removes both gates in the same cycle.
  always_comb begin
    hs_en_o = (state == ST_HS_ON) && !kill;
    ls_en_o = (state == ST_LS_ON) && !kill;
  end

endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic pwm_float_i,
  input logic mode_float_i,
  input logic uvlo_i,
  input logic hs_below_i,
  input logic ls_below_i,
  input logic hs_en_o,
  input logic ls_en_o
);

  assert_no_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  assert_hs_waits_ls_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(ls_below_i));

  assert_ls_waits_hs_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> $past(hs_below_i));

  assert_hs_follows_pwm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(pwm_i));

  assert_ls_follows_pwm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(pwm_i));

  assert_pwm_float_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_float_i |=> (!hs_en_o && !ls_en_o));

  assert_mode_float_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_float_i |=> (!hs_en_o && !ls_en_o));

  assert_uvlo_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (!hs_en_o && !ls_en_o));

endmodule

bind buck_gate_seq buck_gate_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwm_i        (pwm_i),
  .pwm_float_i  (pwm_float_i),
  .mode_float_i (mode_float_i),
  .uvlo_i       (uvlo_i),
  .hs_below_i   (hs_below_i),
  .ls_below_i   (ls_below_i),
  .hs_en_o      (hs_en_o),
  .ls_en_o      (ls_en_o)
);

// File: tb/buck_gate_seq_test.sv
`timescale 1ns/1ps
module buck_gate_seq_test;

  localparam int unsigned MIN_ON = 8;
  localparam int unsigned FB_TO  = 6;

  logic clk = 1'b0;
  logic rst_ni;
  logic pwm, pwm_float, mode, mode_float, uvlo;
  logic hs_below, ls_below, zc;
  logic hs, ls;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  buck_gate_seq #(.MIN_ON_CYC(MIN_ON), .FB_TIMEOUT_CYC(FB_TO)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .pwm_i        (pwm),
    .pwm_float_i  (pwm_float),
    .mode_i       (mode),
    .mode_float_i (mode_float),
    .uvlo_i       (uvlo),
    .hs_below_i   (hs_below),
    .ls_below_i   (ls_below),
    .zero_cross_i (zc),
    .hs_en_o      (hs),
    .ls_en_o      (ls)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic eh, input logic el, input string tag);
    n_chk++;
    if (hs !== eh || ls !== el) begin
      n_err++;
      $display("FAIL %s: got hs=%b ls=%b, expected hs=%b ls=%b", tag, hs, ls, eh, el);
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0; pwm = 1'b0; pwm_float = 1'b0; mode = 1'b1; mode_float = 1'b0;
    uvlo = 1'b0; hs_below = 1'b1; ls_below = 1'b1; zc = 1'b0;
    step(3);
    chk(1'b0, 1'b0, "R1 during reset");
    rst_ni = 1'b1;
    #1 chk(1'b0, 1'b0, "R1 after release");
    @(negedge clk);
  endtask

  task automatic test_ccm();
    step(1); chk(1'b0, 1'b1, "R3 pwm low gives low side");
    pwm = 1'b1; step(1); chk(1'b0, 1'b0, "R3 dead cycle before high side");
    step(1); chk(1'b1, 1'b0, "R3 pwm high gives high side");
    pwm = 1'b0; step(1); chk(1'b0, 1'b0, "R3 dead cycle before low side");
    step(1); chk(1'b0, 1'b1, "R3 low side back on");
  endtask

  task automatic test_deadtime();
    ls_below = 1'b0; pwm = 1'b1;
    step(1); chk(1'b0, 1'b0, "R4 low side released");
    step(3); chk(1'b0, 1'b0, "R4 high side waits for ls_below");
    ls_below = 1'b1; step(1); chk(1'b1, 1'b0, "R4 high side after ls_below");
    hs_below = 1'b0; pwm = 1'b0;
    step(3); chk(1'b0, 1'b0, "R4 low side waits for hs_below");
    hs_below = 1'b1; step(1); chk(1'b0, 1'b1, "R4 low side after hs_below");
  endtask

  task automatic test_timeout();
    pwm = 1'b1; step(2); chk(1'b1, 1'b0, "R10 setup high side");
    hs_below = 1'b0; pwm = 1'b0;
    step(7); chk(1'b0, 1'b0, "R10 parked after window");
    hs_below = 1'b1;
    step(3); chk(1'b0, 1'b0, "R10 stays off without pwm edge");
    pwm = 1'b1; step(1); chk(1'b0, 1'b0, "R10 edge releases park");
    step(1); chk(1'b1, 1'b0, "R10 high side after edge");
  endtask

  task automatic test_fb_last_cycle();
    hs_below = 1'b0; pwm = 1'b0;
    step(6); chk(1'b0, 1'b0, "R10 still waiting in last cycle");
    hs_below = 1'b1; step(1); chk(1'b0, 1'b1, "R10 feedback in last cycle honoured");
  endtask

  task automatic test_dcm_min_on();
    pwm = 1'b1; step(2); chk(1'b1, 1'b0, "R5 setup high side");
    mode = 1'b0; zc = 1'b1; pwm = 1'b0;
    step(2); chk(1'b0, 1'b1, "R5 falling edge opens low-side pulse");
    step(7); chk(1'b0, 1'b1, "R6 zero cross ignored before min on-time");
    step(1); chk(1'b0, 1'b0, "R5 zero cross ends pulse at min on-time");
    zc = 1'b0;
    step(3); chk(1'b0, 1'b0, "R11 low side stays off when idle");
  endtask

  task automatic test_dcm_late_zc();
    pwm = 1'b1; step(2); chk(1'b1, 1'b0, "R5 setup high side");
    pwm = 1'b0; step(2); chk(1'b0, 1'b1, "R5 pulse opened");
    step(12); chk(1'b0, 1'b1, "R5 pulse held without zero cross");
    zc = 1'b1; step(1); chk(1'b0, 1'b0, "R5 late zero cross ends pulse");
    zc = 1'b0;
  endtask

  task automatic test_collision();
    pwm = 1'b1; step(2); chk(1'b1, 1'b0, "R6 setup high side");
    pwm = 1'b0; step(2); chk(1'b0, 1'b1, "R6 pulse opened");
    step(7);
    pwm = 1'b1; zc = 1'b1;
    step(1); chk(1'b0, 1'b0, "R6 pwm rise with zero cross at min on-time");
    zc = 1'b0;
    step(1); chk(1'b1, 1'b0, "R6 high side follows");
  endtask

  task automatic test_idle_to_ccm();
    pwm = 1'b0; zc = 1'b1;
    step(2); chk(1'b0, 1'b1, "R11 pulse opened");
    step(8); chk(1'b0, 1'b0, "R11 pulse ended, idle");
    zc = 1'b0; mode = 1'b1;
    step(1); chk(1'b0, 1'b0, "R11 mode switch dead cycle");
    step(1); chk(1'b0, 1'b1, "R11 continuous mode turns low side on");
  endtask

  task automatic test_pwm_float();
    pwm = 1'b1; step(2); chk(1'b1, 1'b0, "R7 setup high side");
    pwm_float = 1'b1;
    #1 chk(1'b0, 1'b0, "R7 same-cycle off");
    step(2); chk(1'b0, 1'b0, "R7 held off");
    pwm_float = 1'b0;
    step(1); chk(1'b0, 1'b0, "R7 release dead cycle");
    step(1); chk(1'b1, 1'b0, "R7 resumes");
  endtask

  task automatic test_mode_float();
    pwm = 1'b0; step(2); chk(1'b0, 1'b1, "R8 setup low side");
    mode_float = 1'b1;
    #1 chk(1'b0, 1'b0, "R8 same-cycle off");
    @(negedge clk);
    pwm = 1'b1; step(2); chk(1'b0, 1'b0, "R8 off with pwm high");
    pwm = 1'b0; step(1); chk(1'b0, 1'b0, "R8 off with pwm low");
    mode_float = 1'b0;
    step(2); chk(1'b0, 1'b1, "R8 resumes");
  endtask

  task automatic test_uvlo();
    pwm = 1'b1; step(2); chk(1'b1, 1'b0, "R9 setup high side");
    uvlo = 1'b1;
    #1 chk(1'b0, 1'b0, "R9 same-cycle off");
    @(negedge clk);
    pwm = 1'b0; step(2); chk(1'b0, 1'b0, "R9 off with pwm low");
    pwm = 1'b1; step(2); chk(1'b0, 1'b0, "R9 off with pwm high");
    uvlo = 1'b0;
    step(2); chk(1'b1, 1'b0, "R9 resumes after lockout");
  endtask

  initial begin
    test_reset();
    test_ccm();
    test_deadtime();
    test_timeout();
    test_fb_last_cycle();
    test_dcm_min_on();
    test_dcm_late_zc();
    test_collision();
    test_idle_to_ccm();
    test_pwm_float();
    test_mode_float();
    test_uvlo();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule